// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block sits on the host side of a management bus. It turns a single logical register read or write into the series of primitive accesses that an indirectly addressed management target needs. Such a target exposes only two registers at its bus address: a command register and a data register. The block polls the busy flag in the command register, issues a command word that names the internal device and register, polls again, and then moves the data. When the target is strapped to bus address zero, it answers every bus address directly. In that case the block skips the whole expansion and issues one primitive access at the internal device address.

The primitive side is a plain request/acknowledge port. The block raises `prim_req` with an operation, a bus address, a register number and write data, and holds them until the bus engine answers with a one-cycle `prim_ack`. The same cycle carries `prim_fail` and the read data. The serial shifting itself is done elsewhere. Busy polls are paced by a cycle prescaler (`TICK_CYCLES`, about 1 ms at the system clock) and bounded by `POLL_LIMIT` attempts. Every request ends in one `rsp_done` pulse, which comes with an error flag and a timeout flag.

Top module: `ind_reg_seq`

## Requirements
- R1: After reset the block is idle (`seq_idle`=1), `prim_req` is 0 and `rsp_done` is 0. While idle, `prim_req` stays 0.
- R2: An indirect read (`tgt_addr`≠0) issues these primitives in order: busy polls (reads of register 0 at `tgt_addr`), one write of the read command to register 0, busy polls again, and one read of register 1. The value of that last read is returned on `rsp_rdata`.
- R3: An indirect write issues these primitives in order: busy polls, a write of `req_wdata` to register 1, a write of the write command to register 0, and busy polls. The request completes only after the last poll succeeds.
- R4: The command word has bit 15 set (busy) and bit 12 set. Bits 11:10 are 2'b10 for a read and 2'b01 for a write. Bits 9:5 hold `req_dev` and bits 4:0 hold `req_reg`.
- R5: With `tgt_addr`=0, a request makes exactly one primitive access. It uses the requested direction, bus address `req_dev`, register `req_reg` and `req_wdata`, and a read returns its value.
- R6: A poll succeeds only when `prim_fail` is 0 and bit 15 of the read value is 0. A failed primitive during a poll counts as an unsuccessful attempt, not as an abort.
- R7: After an unsuccessful poll, the next poll request is raised exactly `TICK_CYCLES` cycles after the acknowledge edge.
- R8: After `POLL_LIMIT` unsuccessful attempts in one poll phase, the request ends with `rsp_err`=1 and `rsp_tmo`=1, and no further primitive is issued.
- R9: A `prim_fail` on any non-poll step (or on the direct access) ends the request at once with `rsp_err`=1 and `rsp_tmo`=0, and no further primitive is issued.
- R10: `prim_req` and all primitive fields stay unchanged until `prim_ack` is seen.
- R11: `req_start` is accepted only while `seq_idle` is 1. A start pulse during a running request has no effect on its primitives or outcome, and produces no extra `rsp_done`.
- R12: `rsp_done` is a single-cycle pulse. `rsp_err`, `rsp_tmo` and `rsp_rdata` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start a logical access (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Internal device address |
| req_reg | input | 5 | Register number inside the device |
| req_wdata | input | 16 | Data for a write |
| tgt_addr | input | 5 | Target bus address, 0 selects direct mode |
| seq_idle | output | 1 | Ready for a new request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Last request failed |
| rsp_tmo | output | 1 | Last failure was a busy timeout |
| rsp_rdata | output | 16 | Data of the last successful read |
| prim_req | output | 1 | Primitive access request |
| prim_write | output | 1 | Primitive direction, 1 = write |
| prim_phy | output | 5 | Primitive bus address |
| prim_reg | output | 5 | Primitive register number |
| prim_wdata | output | 16 | Primitive write data |
| prim_ack | input | 1 | One-cycle primitive completion |
| prim_fail | input | 1 | Primitive failed (valid with ack) |
| prim_rdata | input | 16 | Primitive read data (valid with ack) |

## Verification
Several rules are checked on every cycle by properties: the primitive request is held stable until acknowledged, nothing is requested while idle, and the done pulse lasts one cycle. The first primitive after a start goes to the right place in each mode, every indirect command word carries a legal opcode, and a failure on a non-poll step ends the request in the next cycle with a plain error. The exact order of primitives, the counting of poll attempts up to the timeout, the exact retry spacing and the returned data depend on the target's answers over a whole request. Only the bench's scenarios can show these. It uses a responder model with random latency, scripted busy counts and injected failures.

// File: rtl/ind_seq_pkg.sv
package ind_seq_pkg;

  localparam int FLD_W = 5;
  localparam int CMD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_GAP,
    ST_DATA_WR,
    ST_CMD_WR,
    ST_DATA_RD,
    ST_DIRECT
  } seq_state_e;

  // busy flag, clause-22 style marker, 2-bit opcode, device and register fields
  function automatic logic [CMD_W-1:0] build_cmd(input logic             wr,
                                                 input logic [FLD_W-1:0] dev,
                                                 input logic [FLD_W-1:0] rg);
    logic [CMD_W-1:0] w;
    w        = '0;
    w[15]    = 1'b1;
    w[12]    = 1'b1;
    w[11:10] = wr ? 2'b01 : 2'b10;
    w[9:5]   = dev;
    w[4:0]   = rg;
    return w;
  endfunction

endpackage

// File: rtl/ind_rst_sync.sv
module ind_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/ind_poll_pacer.sv
module ind_poll_pacer #(
  parameter int TICK_CYCLES = 50000,
  parameter int POLL_LIMIT  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic exhausted,
  output logic expire
);

  localparam int CNT_W = $clog2(TICK_CYCLES + 1);
  localparam int TRY_W = $clog2(POLL_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TRY_W-1:0] tries_q, tries_d;
  logic             run_q, run_d;

  assign exhausted = (tries_q == TRY_W'(POLL_LIMIT - 1));
  assign expire    = run_q && (cnt_q == '0);

  always_comb begin
    cnt_d   = cnt_q;
    tries_d = tries_q;
    run_d   = run_q;
    if (clr) begin
      tries_d = '0;
      run_d   = 1'b0;
    end else if (miss) begin
      tries_d = tries_q + 1'b1;
      cnt_d   = CNT_W'(TICK_CYCLES - 1);
      run_d   = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tries_q <= '0;
      run_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      tries_q <= tries_d;
      run_q   <= run_d;
    end
  end

endmodule

// File: rtl/ind_prim_drive.sv
module ind_prim_drive
  import ind_seq_pkg::*;
#(
  parameter int               DATA_W   = 16,
  parameter logic [FLD_W-1:0] CMD_REG  = 5'd0,
  parameter logic [FLD_W-1:0] DATA_REG = 5'd1
) (
  input  seq_state_e         state,
  input  logic               wr_q,
  input  logic [FLD_W-1:0]   dev_q,
  input  logic [FLD_W-1:0]   reg_q,
  input  logic [FLD_W-1:0]   tgt_q,
  input  logic [DATA_W-1:0]  wd_q,
  output logic               prim_req,
  output logic               prim_write,
  output logic [FLD_W-1:0]   prim_phy,
  output logic [FLD_W-1:0]   prim_reg,
  output logic [DATA_W-1:0]  prim_wdata
);

  logic [CMD_W-1:0] cmd_word;

  assign cmd_word = build_cmd(wr_q, dev_q, reg_q);

  always_comb begin
    prim_req   = 1'b1;
    prim_write = 1'b0;
    prim_phy   = tgt_q;
    prim_reg   = CMD_REG;
    prim_wdata = '0;
    unique case (state)
      ST_POLL: begin
      end
      ST_DATA_WR: begin
        prim_write = 1'b1;
        prim_reg   = DATA_REG;
        prim_wdata = wd_q;
      end
      ST_CMD_WR: begin
        prim_write = 1'b1;
        prim_wdata = DATA_W'(cmd_word);
      end
      ST_DATA_RD: begin
        prim_reg = DATA_REG;
      end
      ST_DIRECT: begin
        prim_write = wr_q;
        prim_phy   = dev_q;
        prim_reg   = reg_q;
        prim_wdata = wr_q ? wd_q : '0;
      end
      default: begin
        prim_req = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq
  import ind_seq_pkg::*;
#(
  parameter int               DATA_W      = 16,
  parameter int               BUSY_BIT    = 15,
  parameter logic [FLD_W-1:0] CMD_REG     = 5'd0,
  parameter logic [FLD_W-1:0] DATA_REG    = 5'd1,
  parameter int               TICK_CYCLES = 50000,
  parameter int               POLL_LIMIT  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [FLD_W-1:0]  req_dev,
  input  logic [FLD_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [FLD_W-1:0]  tgt_addr,
  output logic              seq_idle,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              rsp_tmo,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              prim_req,
  output logic              prim_write,
  output logic [FLD_W-1:0]  prim_phy,
  output logic [FLD_W-1:0]  prim_reg,
  output logic [DATA_W-1:0] prim_wdata,
  input  logic              prim_ack,
  input  logic              prim_fail,
  input  logic [DATA_W-1:0] prim_rdata
);

  logic rst_sync_n;

  seq_state_e        state_q, state_d;
  logic              wr_q;
  logic [FLD_W-1:0]  dev_q, reg_q, tgt_q;
  logic [DATA_W-1:0] wd_q;
  logic              second_q, second_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              tmo_q, tmo_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic accept;
  logic ack;
  logic poll_ok;
  logic pace_clr;
  logic pace_miss;
  logic pace_exhausted;
  logic pace_expire;

  ind_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  ind_poll_pacer #(
    .TICK_CYCLES (TICK_CYCLES),
    .POLL_LIMIT  (POLL_LIMIT)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (pace_clr),
    .miss      (pace_miss),
    .exhausted (pace_exhausted),
    .expire    (pace_expire)
  );

  ind_prim_drive #(
    .DATA_W   (DATA_W),
    .CMD_REG  (CMD_REG),
    .DATA_REG (DATA_REG)
  ) u_drive (
    .state      (state_q),
    .wr_q       (wr_q),
    .dev_q      (dev_q),
    .reg_q      (reg_q),
    .tgt_q      (tgt_q),
    .wd_q       (wd_q),
    .prim_req   (prim_req),
    .prim_write (prim_write),
    .prim_phy   (prim_phy),
    .prim_reg   (prim_reg),
    .prim_wdata (prim_wdata)
  );

  assign ack     = prim_req && prim_ack;
  assign poll_ok = !prim_fail && !prim_rdata[BUSY_BIT];

  always_comb begin
    state_d   = state_q;
    second_d  = second_q;
    done_d    = 1'b0;
    err_d     = err_q;
    tmo_d     = tmo_q;
    rdata_d   = rdata_q;
    accept    = 1'b0;
    pace_clr  = 1'b0;
    pace_miss = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_start) begin
          accept   = 1'b1;
          err_d    = 1'b0;
          tmo_d    = 1'b0;
          second_d = 1'b0;
          pace_clr = 1'b1;
          state_d  = (tgt_addr == '0) ? ST_DIRECT : ST_POLL;
        end
      end
      ST_POLL: begin
        if (ack) begin
          if (poll_ok) begin
            pace_clr = 1'b1;
            if (!second_q) begin
              state_d = wr_q ? ST_DATA_WR : ST_CMD_WR;
            end else if (wr_q) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d = ST_DATA_RD;
            end
          end else if (pace_exhausted) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
            tmo_d   = 1'b1;
          end else begin
            pace_miss = 1'b1;
            state_d   = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (pace_expire) state_d = ST_POLL;
      end
      ST_DATA_WR: begin
        if (ack) begin
          if (prim_fail) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
          end else begin
            state_d = ST_CMD_WR;
          end
        end
      end
      ST_CMD_WR: begin
        if (ack) begin
          if (prim_fail) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
          end else begin
            second_d = 1'b1;
            pace_clr = 1'b1;
            state_d  = ST_POLL;
          end
        end
      end
      ST_DATA_RD, ST_DIRECT: begin
        if (ack) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (prim_fail)                       err_d   = 1'b1;
          else if (!(state_q == ST_DIRECT && wr_q)) rdata_d = prim_rdata;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      tmo_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
      done_q   <= done_d;
      err_q    <= err_d;
      tmo_q    <= tmo_d;
      rdata_q  <= rdata_d;
    end
  end

  // request capture, enabled only when a start is accepted
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q  <= 1'b0;
      dev_q <= '0;
      reg_q <= '0;
      tgt_q <= '0;
      wd_q  <= '0;
    end else if (accept) begin
      wr_q  <= req_write;
      dev_q <= req_dev;
      reg_q <= req_reg;
      tgt_q <= tgt_addr;
      wd_q  <= req_wdata;
    end
  end

  assign seq_idle  = (state_q == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_tmo   = tmo_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/ind_reg_seq_chk.sv
module ind_reg_seq_chk #(
  parameter int         DATA_W   = 16,
  parameter logic [4:0] CMD_REG  = 5'd0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_start,
  input logic              req_write,
  input logic [4:0]        req_dev,
  input logic [4:0]        req_reg,
  input logic [4:0]        tgt_addr,
  input logic              seq_idle,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              rsp_tmo,
  input logic              prim_req,
  input logic              prim_write,
  input logic [4:0]        prim_phy,
  input logic [4:0]        prim_reg,
  input logic [DATA_W-1:0] prim_wdata,
  input logic              prim_ack,
  input logic              prim_fail
);

  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dir_q <= 1'b0;
    else if (seq_idle && req_start) dir_q <= (tgt_addr == 5'd0);
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> !prim_req);

  assert_first_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && seq_idle && tgt_addr != 5'd0) |=>
      (prim_req && !prim_write && prim_phy == $past(tgt_addr) && prim_reg == CMD_REG));

  assert_cmd_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_req && prim_write && !dir_q && prim_reg == CMD_REG) |->
      (prim_wdata[15:10] == 6'b100110 || prim_wdata[15:10] == 6'b100101));

  assert_direct_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && seq_idle && tgt_addr == 5'd0) |=>
      (prim_req && prim_write == $past(req_write) &&
       prim_phy == $past(req_dev) && prim_reg == $past(req_reg)));

  assert_tmo_is_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_tmo |-> rsp_err);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_req && prim_ack && prim_fail && (dir_q || prim_write || prim_reg != CMD_REG)) |=>
      (rsp_done && rsp_err && !rsp_tmo));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_req && !prim_ack) |=>
      (prim_req && $stable(prim_write) && $stable(prim_phy) &&
       $stable(prim_reg) && $stable(prim_wdata)));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> seq_idle);

endmodule

bind ind_reg_seq ind_reg_seq_chk #(
  .DATA_W  (DATA_W),
  .CMD_REG (CMD_REG)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_start  (req_start),
  .req_write  (req_write),
  .req_dev    (req_dev),
  .req_reg    (req_reg),
  .tgt_addr   (tgt_addr),
  .seq_idle   (seq_idle),
  .rsp_done   (rsp_done),
  .rsp_err    (rsp_err),
  .rsp_tmo    (rsp_tmo),
  .prim_req   (prim_req),
  .prim_write (prim_write),
  .prim_phy   (prim_phy),
  .prim_reg   (prim_reg),
  .prim_wdata (prim_wdata),
  .prim_ack   (prim_ack),
  .prim_fail  (prim_fail)
);

// File: tb/ind_reg_seq_tb.sv
module ind_reg_seq_tb;

  localparam int TICK  = 4;
  localparam int LIMIT = 100;
  localparam int LOGN  = 256;

  logic        clk;
  logic        rst_n;
  logic        req_start, req_write;
  logic [4:0]  req_dev, req_reg, tgt_addr;
  logic [15:0] req_wdata;
  logic        seq_idle, rsp_done, rsp_err, rsp_tmo;
  logic [15:0] rsp_rdata;
  logic        prim_req, prim_write;
  logic [4:0]  prim_phy, prim_reg;
  logic [15:0] prim_wdata;
  logic        prim_ack, prim_fail;
  logic [15:0] prim_rdata;

  ind_reg_seq #(.TICK_CYCLES(TICK), .POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata), .tgt_addr(tgt_addr),
    .seq_idle(seq_idle), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_tmo(rsp_tmo),
    .rsp_rdata(rsp_rdata), .prim_req(prim_req), .prim_write(prim_write),
    .prim_phy(prim_phy), .prim_reg(prim_reg), .prim_wdata(prim_wdata),
    .prim_ack(prim_ack), .prim_fail(prim_fail), .prim_rdata(prim_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  int cyc = 0;

  // responder state
  int          busy_left, busy2, fail_idx, lat_max, lat_cnt, lat_tgt, gap_run;
  logic [4:0]  cur_tgt;
  logic [15:0] data_val;
  int          n_log;
  logic        l_w   [LOGN];
  logic [4:0]  l_phy [LOGN];
  logic [4:0]  l_reg [LOGN];
  logic [15:0] l_wd  [LOGN];
  int          l_gap [LOGN];

  // expected sequence
  int          e_n;
  logic        e_w   [LOGN];
  logic [4:0]  e_phy [LOGN];
  logic [4:0]  e_reg [LOGN];
  logic [15:0] e_wd  [LOGN];

  // captured outcome
  logic        o_err, o_tmo;
  logic [15:0] o_rdata;

  function automatic logic [15:0] exp_cmd(input logic wr, input logic [4:0] dev, input logic [4:0] rg);
    return {1'b1, 2'b00, 1'b1, (wr ? 2'b01 : 2'b10), dev, rg};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rsp_done) n_done++;
    end
  end

  // target responder
  initial begin
    prim_ack = 1'b0; prim_fail = 1'b0; prim_rdata = '0;
    lat_cnt = 0; lat_tgt = 0; gap_run = 0; n_log = 0;
    forever begin
      @(negedge clk);
      if (prim_ack) begin
        prim_ack  = 1'b0;
        prim_fail = 1'b0;
        gap_run   = prim_req ? 0 : 1;
      end else if (prim_req) begin
        if (lat_cnt < lat_tgt) lat_cnt++;
        else begin
          lat_cnt = 0;
          lat_tgt = $urandom_range(0, lat_max);
          if (n_log < LOGN) begin
            l_w[n_log] = prim_write; l_phy[n_log] = prim_phy; l_reg[n_log] = prim_reg;
            l_wd[n_log] = prim_wdata; l_gap[n_log] = gap_run;
          end
          prim_fail = (n_log == fail_idx);
          if (!prim_write) begin
            if (prim_fail) prim_rdata = 16'h0000;
            else if (cur_tgt != 0 && prim_reg == 5'd0) begin
              if (busy_left > 0) begin
                prim_rdata = 16'h8000 | 16'($urandom_range(0, 16'h7fff));
                busy_left--;
              end else prim_rdata = 16'($urandom_range(0, 16'h7fff));
            end else prim_rdata = data_val;
          end else begin
            prim_rdata = 16'($urandom);
            if (!prim_fail && cur_tgt != 0 && prim_reg == 5'd0) busy_left = busy2;
          end
          prim_ack = 1'b1;
          n_log++;
        end
      end else gap_run++;
    end
  end

  task automatic build_exp(input logic wr, input logic [4:0] dev, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [4:0] tg, input int b1, input int b2);
    e_n = 0;
    if (tg == 0) begin
      e_w[0] = wr; e_phy[0] = dev; e_reg[0] = rg; e_wd[0] = wd; e_n = 1;
      return;
    end
    for (int i = 0; i <= b1; i++) begin
      e_w[e_n] = 0; e_phy[e_n] = tg; e_reg[e_n] = 0; e_wd[e_n] = 0; e_n++;
    end
    if (wr) begin
      e_w[e_n] = 1; e_phy[e_n] = tg; e_reg[e_n] = 1; e_wd[e_n] = wd; e_n++;
    end
    e_w[e_n] = 1; e_phy[e_n] = tg; e_reg[e_n] = 0; e_wd[e_n] = exp_cmd(wr, dev, rg); e_n++;
    for (int i = 0; i <= b2; i++) begin
      e_w[e_n] = 0; e_phy[e_n] = tg; e_reg[e_n] = 0; e_wd[e_n] = 0; e_n++;
    end
    if (!wr) begin
      e_w[e_n] = 0; e_phy[e_n] = tg; e_reg[e_n] = 1; e_wd[e_n] = 0; e_n++;
    end
  endtask

  task automatic check_seq(input string tag);
    int bad;
    bad = -1;
    for (int i = 0; i < e_n && i < n_log && i < LOGN; i++) begin
      if (bad < 0 && (l_w[i] != e_w[i] || l_phy[i] != e_phy[i] || l_reg[i] != e_reg[i] ||
                      (e_w[i] && l_wd[i] != e_wd[i]))) bad = i;
    end
    chk(n_log == e_n, {tag, " primitive count"}, n_log, e_n);
    if (bad >= 0)
      chk(1'b0, {tag, " primitive fields"},
          {l_w[bad], l_phy[bad], l_reg[bad], l_wd[bad]},
          {e_w[bad], e_phy[bad], e_reg[bad], e_wd[bad]});
    else chk(1'b1, tag, 0, 0);
  endtask

  task automatic run(input logic wr, input logic [4:0] dev, input logic [4:0] rg,
                     input logic [15:0] wd, input logic [4:0] tg, input int b1, input int b2,
                     input int fidx, input logic [15:0] dv, input bit intrude);
    busy_left = b1; busy2 = b2; fail_idx = fidx; data_val = dv; cur_tgt = tg;
    n_log = 0; gap_run = 0;
    @(negedge clk);
    req_start = 1'b1; req_write = wr; req_dev = dev; req_reg = rg; req_wdata = wd; tgt_addr = tg;
    @(negedge clk);
    req_start = 1'b0;
    if (intrude) begin
      repeat (2) @(negedge clk);
      req_start = 1'b1; req_write = ~wr; req_dev = ~dev; req_reg = ~rg; tgt_addr = 5'd0;
      @(negedge clk);
      req_start = 1'b0;
    end
    while (!rsp_done) @(negedge clk);
    o_err = rsp_err; o_tmo = rsp_tmo; o_rdata = rsp_rdata;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int seed;
    int nd;
    logic wr;
    logic [4:0] dev, rg, tg;
    logic [15:0] wd, dv;
    int b1, b2;
    seed = $urandom(32'h5eed1234);
    lat_max = 2; fail_idx = -1; cur_tgt = 0; busy_left = 0; busy2 = 0; data_val = 0;
    req_start = 0; req_write = 0; req_dev = 0; req_reg = 0; req_wdata = 0; tgt_addr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(seq_idle == 1'b1, "R1 idle after reset", seq_idle, 1);
    chk(prim_req == 1'b0 && rsp_done == 1'b0, "R1 quiet after reset", {prim_req, rsp_done}, 0);

    // R2 indirect read with busy in both phases, R7 spacing
    build_exp(0, 5'd3, 5'd17, 16'h0, 5'd16, 2, 1);
    run(0, 5'd3, 5'd17, 16'h0, 5'd16, 2, 1, -1, 16'hbeef, 0);
    check_seq("R2 indirect read");
    chk(!o_err && o_rdata == 16'hbeef, "R2 read data", {o_err, o_rdata}, 16'hbeef);
    chk(l_gap[1] == TICK && l_gap[2] == TICK, "R7 poll spacing", l_gap[1], TICK);
    chk(l_wd[3] == 16'h9871, "R4 read command word", l_wd[3], 16'h9871);

    // R3 indirect write
    build_exp(1, 5'd31, 5'd0, 16'h1234, 5'd28, 0, 3);
    run(1, 5'd31, 5'd0, 16'h1234, 5'd28, 0, 3, -1, 16'h0, 0);
    check_seq("R3 indirect write");
    chk(!o_err && !o_tmo, "R3 write ok", {o_err, o_tmo}, 0);
    chk(l_wd[2] == 16'h97e0, "R4 write command word", l_wd[2], 16'h97e0);

    // R5 direct read and write
    build_exp(0, 5'd9, 5'd4, 16'h0, 5'd0, 0, 0);
    run(0, 5'd9, 5'd4, 16'h0, 5'd0, 5, 5, -1, 16'hf00d, 0);
    check_seq("R5 direct read");
    chk(!o_err && o_rdata == 16'hf00d, "R5 direct data", o_rdata, 16'hf00d);
    build_exp(1, 5'd2, 5'd22, 16'hcafe, 5'd0, 0, 0);
    run(1, 5'd2, 5'd22, 16'hcafe, 5'd0, 0, 0, -1, 16'h0, 0);
    check_seq("R5 direct write");

    // R6 failed poll primitive with clear busy bit counts as a miss
    build_exp(0, 5'd1, 5'd1, 16'h0, 5'd5, 1, 0);
    run(0, 5'd1, 5'd1, 16'h0, 5'd5, 0, 0, 0, 16'h0a0a, 0);
    check_seq("R6 poll failure retried");
    chk(!o_err && o_rdata == 16'h0a0a, "R6 outcome", {o_err, o_rdata}, 16'h0a0a);
    chk(l_gap[1] == TICK, "R7 spacing after failed poll", l_gap[1], TICK);

    // R8 timeouts in first and second poll phase
    run(0, 5'd7, 5'd7, 16'h0, 5'd12, 1000, 0, -1, 16'h0, 0);
    chk(n_log == LIMIT, "R8 first phase poll count", n_log, LIMIT);
    chk(o_err && o_tmo, "R8 first phase timeout flags", {o_err, o_tmo}, 3);
    run(1, 5'd7, 5'd7, 16'h55aa, 5'd12, 0, 1000, -1, 16'h0, 0);
    chk(n_log == LIMIT + 3, "R8 second phase count", n_log, LIMIT + 3);
    chk(o_err && o_tmo, "R8 second phase flags", {o_err, o_tmo}, 3);

    // R9 aborts
    run(0, 5'd4, 5'd8, 16'h0, 5'd3, 0, 0, 3, 16'h1111, 0);
    chk(n_log == 4 && o_err && !o_tmo, "R9 data read failure", {n_log, o_err, o_tmo}, {32'd4, 2'b10});
    run(1, 5'd4, 5'd8, 16'h7777, 5'd3, 0, 0, 1, 16'h0, 0);
    chk(n_log == 2 && o_err && !o_tmo, "R9 data write failure", {n_log, o_err, o_tmo}, {32'd2, 2'b10});
    run(0, 5'd4, 5'd8, 16'h0, 5'd3, 0, 0, 1, 16'h0, 0);
    chk(n_log == 2 && o_err && !o_tmo, "R9 command write failure", {n_log, o_err, o_tmo}, {32'd2, 2'b10});
    run(0, 5'd4, 5'd8, 16'h0, 5'd0, 0, 0, 0, 16'h0, 0);
    chk(n_log == 1 && o_err && !o_tmo, "R9 direct failure", {n_log, o_err, o_tmo}, {32'd1, 2'b10});
    chk(o_rdata == 16'h0a0a, "R12 read data held after error", o_rdata, 16'h0a0a);

    // R11 start while busy is ignored
    nd = n_done;
    build_exp(1, 5'd6, 5'd19, 16'habcd, 5'd20, 1, 1);
    run(1, 5'd6, 5'd19, 16'habcd, 5'd20, 1, 1, -1, 16'h0, 1);
    check_seq("R11 busy start ignored");
    chk(n_done - nd == 1, "R11 single done", n_done - nd, 1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      wr = 1'($urandom); dev = 5'($urandom); rg = 5'($urandom); wd = 16'($urandom);
      dv = 16'($urandom);
      tg = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
      b1 = $urandom_range(0, 3); b2 = $urandom_range(0, 3);
      nd = n_done;
      build_exp(wr, dev, rg, wd, tg, (tg == 0) ? 0 : b1, (tg == 0) ? 0 : b2);
      run(wr, dev, rg, wd, tg, b1, b2, -1, dv, 0);
      check_seq(wr ? "R3 R5 random write" : "R2 R5 random read");
      chk(!o_err && !o_tmo && (wr || o_rdata == dv), "R12 random outcome", o_rdata, dv);
      chk(n_done - nd == 1, "R12 one done per request", n_done - nd, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule